// File: doc/BRIEF.md
# Processor-Side Parallel Port with Memory Bank Decode

This block is a six-line parallel port that sits inside the processor's own address space at the two lowest byte addresses. A direction register picks, line by line, whether each port line drives its pin or listens to it. A data latch holds the value driven on output lines. Reading back the data address returns the latch on output lines and a synchronised copy of the pin on input lines.

Three of the lines also steer the memory map. Each line picks what answers in one of three upper windows. Line 0 picks ROM or RAM at A000–BFFF. Line 1 picks ROM or RAM at E000–FFFF. Line 2 picks the I/O devices or the character ROM at D000–DFFF. A line set as an input counts as pulled high. For every bus address the block raises exactly one chip select. Of the remaining lines, line 3 is meant as a tape-write output, line 4 as a tape-sense input and line 5 as a motor-control output.

Top module: `proc_port_bankmap`

## Requirements
- R1: During and after reset, and before any write, the direction register holds 6'b101111 and the data latch holds 6'b000111. So pin_oe_o = 6'h2F and pin_out_o = 6'h07.
- R2: A write to address 0 loads bus_wdata_i[5:0] into the direction register. The new value shows on pin_oe_o after that clock edge. A read of address 0 returns {2'b00, direction}.
- R3: A write to address 1 loads bus_wdata_i[5:0] into the data latch. The new value shows on pin_out_o after that clock edge, on every line, whatever the direction.
- R4: A read of address 1 returns {2'b00, v}. For each bit i, v[i] is the latch bit when direction bit i is 1. When direction bit i is 0, v[i] is the value pin_in_i[i] had SYNC_STAGES clock edges earlier.
- R5: Addresses A000–BFFF select cs_o bit 1 (low ROM) when line 0 is effectively high, and cs_o bit 0 (RAM) otherwise.
- R6: Addresses E000–FFFF select cs_o bit 2 (high ROM) when line 1 is effectively high, and cs_o bit 0 (RAM) otherwise.
- R7: Addresses D000–DFFF select cs_o bit 4 (I/O) when line 2 is effectively high, and cs_o bit 3 (character ROM) otherwise.
- R8: A bank line whose direction bit is 0 counts as high for decode, whatever its latch bit holds.
- R9: Addresses 0 and 1 select only cs_o bit 5 (port registers), never RAM. Every other address outside the three windows selects cs_o bit 0. Exactly one bit of cs_o is set at all times.
- R10: A write to any address other than 0 or 1 leaves both port registers unchanged. A read of such an address returns 8'h00 on bus_rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Bus address |
| bus_wr_i | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for the port registers |
| cs_o | output | 6 | One-hot chip select: 0 RAM, 1 low ROM, 2 high ROM, 3 character ROM, 4 I/O, 5 port registers |
| pin_oe_o | output | 6 | Per-line output enable (direction register) |
| pin_out_o | output | 6 | Per-line output value (data latch) |
| pin_in_i | input | 6 | Pin levels, sampled through a synchroniser |

## Verification
A corrupted direction or latch bit shows on pin_oe_o or pin_out_o in the same cycle. For lines 0 to 2 it also flips a window's chip select as soon as an address in that window is presented. A fault in the synchroniser shows only through address 1 reads of input lines. Those reads are off by whole cycles relative to the pin history, so the bench drives pin patterns that change every cycle. Decode faults at window edges show on cs_o at the first or last address of a window. The bench therefore probes both bounds of every window and the addresses just outside them.

// File: rtl/pport_pkg.sv
`timescale 1ns/1ps
package pport_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PORT_W = 6;

  typedef enum int unsigned {
    CS_RAM     = 0,
    CS_LO_ROM  = 1,
    CS_HI_ROM  = 2,
    CS_CHR_ROM = 3,
    CS_IO      = 4,
    CS_PORT    = 5
  } cs_idx_e;
  localparam int CS_N = 6;

  localparam logic [PORT_W-1:0] DIR_RST = 6'b101111;
  localparam logic [PORT_W-1:0] DAT_RST = 6'b000111;

  // port lines that steer the map
  localparam int LN_LO = 0;
  localparam int LN_HI = 1;
  localparam int LN_IO = 2;

  localparam logic [ADDR_W-1:0] DIR_ADDR = 16'h0000;
  localparam logic [ADDR_W-1:0] DAT_ADDR = 16'h0001;

  localparam logic [ADDR_W-1:0] LO_FIRST = 16'hA000;
  localparam logic [ADDR_W-1:0] LO_LAST  = 16'hBFFF;
  localparam logic [ADDR_W-1:0] IO_FIRST = 16'hD000;
  localparam logic [ADDR_W-1:0] IO_LAST  = 16'hDFFF;
  localparam logic [ADDR_W-1:0] HI_FIRST = 16'hE000;
  localparam logic [ADDR_W-1:0] HI_LAST  = 16'hFFFF;
endpackage

// File: rtl/pport_sync.sv
`timescale 1ns/1ps
module pport_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stg
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[g] <= '0;
          else         stg_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[g] <= '0;
          else         stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pport_regs.sv
`timescale 1ns/1ps
module pport_regs
  import pport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [PORT_W-1:0] pin_sync_i,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] dat_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - PORT_W;

  logic [PORT_W-1:0] dir_q, dat_q, merged;
  logic              hit_dir, hit_dat;
  logic              unused_w;

  assign hit_dir  = (bus_addr_i == DIR_ADDR);
  assign hit_dat  = (bus_addr_i == DAT_ADDR);
  assign unused_w = ^bus_wdata_i[DATA_W-1:PORT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_RST;
      dat_q <= DAT_RST;
    end else if (bus_wr_i) begin
      if (hit_dir) dir_q <= bus_wdata_i[PORT_W-1:0];
      if (hit_dat) dat_q <= bus_wdata_i[PORT_W-1:0];
    end
  end

  // outputs from latch, inputs from synchronised pins
  assign merged = (dir_q & dat_q) | (~dir_q & pin_sync_i);

  always_comb begin
    rdata_o = '0;
    if (hit_dir)      rdata_o = {{PAD_W{1'b0}}, dir_q};
    else if (hit_dat) rdata_o = {{PAD_W{1'b0}}, merged};
  end

  assign dir_o = dir_q;
  assign dat_o = dat_q;

  // R2
  dir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && hit_dir) |=> (dir_o == $past(bus_wdata_i[PORT_W-1:0])));
  // R3
  dat_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && hit_dat) |=> (dat_o == $past(bus_wdata_i[PORT_W-1:0])));
endmodule

// File: rtl/pport_bank_dec.sv
`timescale 1ns/1ps
module pport_bank_dec
  import pport_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic [PORT_W-1:0] dat_i,
  output logic [CS_N-1:0]   cs_o
);
  logic [PORT_W-1:0] eff;
  logic in_lo, in_hi, in_io, in_port;

  // input-configured lines read as pulled high
  assign eff = dat_i | ~dir_i;

  assign in_port = (addr_i == DIR_ADDR) || (addr_i == DAT_ADDR);
  assign in_lo   = (addr_i >= LO_FIRST) && (addr_i <= LO_LAST);
  assign in_io   = (addr_i >= IO_FIRST) && (addr_i <= IO_LAST);
  assign in_hi   = (addr_i >= HI_FIRST) && (addr_i <= HI_LAST);

  always_comb begin
    cs_o = '0;
    if (in_port)    cs_o[CS_PORT] = 1'b1;
    else if (in_lo) cs_o[eff[LN_LO] ? CS_LO_ROM : CS_RAM] = 1'b1;
    else if (in_io) cs_o[eff[LN_IO] ? CS_IO : CS_CHR_ROM] = 1'b1;
    else if (in_hi) cs_o[eff[LN_HI] ? CS_HI_ROM : CS_RAM] = 1'b1;
    else            cs_o[CS_RAM] = 1'b1;
  end
endmodule

// File: rtl/proc_port_bankmap.sv
`timescale 1ns/1ps
module proc_port_bankmap
  import pport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [CS_N-1:0]   cs_o,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] pin_out_o,
  input  logic [PORT_W-1:0] pin_in_i
);
  logic [PORT_W-1:0] pin_sync, dir, dat;

  pport_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (pin_sync)
  );

  pport_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_addr_i (bus_addr_i),
    .bus_wr_i   (bus_wr_i),
    .bus_wdata_i(bus_wdata_i),
    .pin_sync_i (pin_sync),
    .dir_o      (dir),
    .dat_o      (dat),
    .rdata_o    (bus_rdata_o)
  );

  pport_bank_dec u_dec (
    .addr_i(bus_addr_i),
    .dir_i (dir),
    .dat_i (dat),
    .cs_o  (cs_o)
  );

  assign pin_oe_o  = dir;
  assign pin_out_o = dat;

  // R9
  cs_one_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o) == 1);
  // R10
  stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i > DAT_ADDR) |=> ($stable(pin_oe_o) && $stable(pin_out_o)));
  // R4
  rd_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == DAT_ADDR) |-> (((bus_rdata_o[PORT_W-1:0] ^ pin_out_o) & pin_oe_o) == '0));
  // R8
  pullup_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_oe_o[LN_LO] && bus_addr_i >= LO_FIRST && bus_addr_i <= LO_LAST) |-> cs_o[CS_LO_ROM]);
  // R9
  port_not_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i <= DAT_ADDR) |-> (cs_o[CS_PORT] && !cs_o[CS_RAM]));
endmodule

// File: tb/sim_proc_port_bankmap.sv
`timescale 1ns/1ps
module sim_proc_port_bankmap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [5:0]  cs, oe, pout;
  logic [5:0]  pin = '0;

  int total = 0;
  int fails = 0;
  bit checking = 0;

  // reference state
  int m_dir = 'h2F;
  int m_dat = 'h07;
  int pin_hist[$] = '{0, 0};

  always #2 clk = ~clk;

  proc_port_bankmap u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cs_o(cs),
    .pin_oe_o(oe), .pin_out_o(pout), .pin_in_i(pin)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  function automatic int exp_cs(input int a, input int d, input int v);
    int eff = (v | ~d) & 'h3F;
    if (a < 2)                       return 1 << 5;
    if (a >= 'hA000 && a <= 'hBFFF) return eff[0] ? (1 << 1) : 1;
    if (a >= 'hD000 && a <= 'hDFFF) return eff[2] ? (1 << 4) : (1 << 3);
    if (a >= 'hE000)                return eff[1] ? (1 << 2) : 1;
    return 1;
  endfunction

  function automatic string cs_tag(input int a);
    if (a >= 'hA000 && a <= 'hBFFF) return "R5/R8";
    if (a >= 'hD000 && a <= 'hDFFF) return "R7/R8";
    if (a >= 'hE000)                return "R6/R8";
    return "R9";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 'h2F; m_dat = 'h07; pin_hist = '{0, 0};
    end else begin
      if (wr && addr == 0) m_dir = wdata & 'h3F;
      if (wr && addr == 1) m_dat = wdata & 'h3F;
      pin_hist.push_front(int'(pin));
      void'(pin_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      int er;
      int ecs;
      ecs = exp_cs(addr, m_dir, m_dat);
      chk(cs == ecs[5:0], cs_tag(addr), cs, ecs);
      chk(oe == m_dir[5:0], "R2", oe, m_dir);
      chk(pout == m_dat[5:0], "R3", pout, m_dat);
      if (addr == 0) begin
        er = m_dir;
        chk(rdata == er[7:0], "R2", rdata, er);
      end else if (addr == 1) begin
        er = (m_dir & m_dat) | (~m_dir & pin_hist[$] & 'h3F);
        chk(rdata == er[7:0], "R4", rdata, er);
      end else begin
        chk(rdata == 8'h00, "R10", rdata, 0);
      end
    end
  end

  task automatic cyc(input int a, input bit w, input int d, input int p);
    @(posedge clk); #1;
    addr = a[15:0]; wr = w; wdata = d[7:0]; pin = p[5:0];
  endtask

  task automatic sweep();
    int probe[12] = '{0, 1, 2, 'h9FFF, 'hA000, 'hBFFF, 'hC000, 'hCFFF,
                      'hD000, 'hDFFF, 'hE000, 'hFFFF};
    foreach (probe[k]) cyc(probe[k], 0, 0, k * 5);
  endtask

  initial begin
    #(4 * 100000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values and default map
    chk(oe == 6'h2F, "R1", oe, 'h2F);
    chk(pout == 6'h07, "R1", pout, 'h07);
    addr = 16'hA000; #1;
    chk(cs == 6'b000010, "R1", cs, 'h02);
    addr = 16'hD000; #1;
    chk(cs == 6'b010000, "R1", cs, 'h10);
    addr = 16'hE000; #1;
    chk(cs == 6'b000100, "R1", cs, 'h04);
    rst_n = 1'b1;
    checking = 1;

    sweep();
    // R3 R5 R6 R7: every bank combination with other lines varied
    for (int v = 0; v < 8; v++) begin
      cyc(1, 1, v | ((7 - v) << 3), 0);
      sweep();
    end
    // R8: all inputs, latch low, windows must read as ROM / I/O
    cyc(0, 1, 'h00, 0);
    cyc(1, 1, 'h00, 0);
    sweep();
    // R4: pins changing each cycle while reading data address
    for (int k = 0; k < 20; k++) cyc(1, 0, 0, k * 13);
    cyc(0, 1, 'hD5, 0);
    cyc(1, 1, 'h2A, 0);
    for (int k = 0; k < 20; k++) cyc(1, 0, 0, k * 29);
    sweep();
    // R10: stray writes
    cyc(2, 1, 'hFF, 0);
    cyc('hA000, 1, 'h00, 0);
    cyc('hFFFF, 1, 'hFF, 0);
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    // mixed random traffic
    for (int k = 0; k < 600; k++) begin
      int a;
      int r = $urandom_range(0, 7);
      case (r)
        0, 1: a = r;
        2: a = $urandom_range('hA000, 'hBFFF);
        3: a = $urandom_range('hD000, 'hDFFF);
        4: a = $urandom_range('hE000, 'hFFFF);
        default: a = $urandom_range(2, 'hFFFF);
      endcase
      cyc(a, $urandom_range(0, 2) == 0, $urandom_range(0, 255), $urandom_range(0, 63));
    end
    cyc(3, 0, 0, 0);
    @(posedge clk); #1;
    checking = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule